// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets software reach registers inside an external Ethernet PHY over a two-wire management link that follows IEEE 802.3 clause 22. Software works through two registers. It first writes a 16-bit value into a staging register for outgoing data. It then writes a command word that selects the operation, the PHY address and the register number. The controller builds the full serial frame and clocks it out on the management clock and data pins. For a read, it releases the data pin and shifts in the PHY's reply.

The request bit in the command word works as a busy flag. It reads back as 1 from the cycle after the command is accepted until the frame has finished, and software polls it to learn when the transfer is done. Read results go to a separate read-data register, which holds its value until the next read completes. The management clock is the system clock divided by an even parameter, 40 by default.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: Command word layout: bit 14 requests a write, bit 13 requests a read, bits 12:8 hold the PHY address and bits 4:0 the register number. Bits 15 and 7:5 read back as 0. A command written while idle is stored. If neither request bit is set, no transfer starts and mdc stays low.
- R2: The request bit reads back as 1 from the first cycle after the accepting edge and for exactly 64 x CLK_DIV cycles. It then clears, and the address and register fields keep their values.
- R3: mdc is low when idle. Each bit of a frame lasts CLK_DIV clocks: mdc is low for the first CLK_DIV/2 clocks and high for the second half.
- R4: A frame is sent MSB first and has this order: 32 ones, start 01, opcode (10 for read, 01 for write), 5-bit PHY address, 5-bit register, turnaround, 16 data bits. A write sends turnaround 10. mdio_out changes only while mdc is low.
- R5: A write sends the value the write-data register held on the accepting edge. Later writes to that register do not change the frame in flight.
- R6: For a read, mdio_oe is low for the two turnaround bits and the 16 data bits. mdio_in is sampled when mdc rises. The 16 bits appear on rd_data on the edge where the request bit clears.
- R7: rd_data changes only when a read completes. Write transfers leave it unchanged.
- R8: A command written while a transfer is running is ignored. The readback, the frame and the transfer length are all unaffected.
- R9: A command with both request bits set is carried out as a read and reads back with only bit 13 set.
- R10: While reset is asserted, cmd_rdbk and rd_data are 0, mdc and mdio_oe are low, and mdio_out is high.
- R11: mdio_oe is low whenever no transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 command word, 1 write-data register |
| reg_wdata | input | 16 | Value written to the selected register |
| mdio_in | input | 1 | Management data from the pin |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data to the pin |
| mdio_oe | output | 1 | Output enable for the data pin |
| cmd_rdbk | output | 16 | Command word readback with live request bits |
| rd_data | output | 16 | Result of the last completed read |

## Verification
A command or write-data write takes effect at the clock edge where reg_wr_en is high. The request bit is visible one cycle after that edge. mdc rises CLK_DIV/2 cycles into each bit period and falls at the end of it. The request bit and the new rd_data both change exactly 64 x CLK_DIV cycles after the accepting edge. The bench's behavioural model advances by one system clock at each falling clock edge, using the inputs the design saw at the rising edge just before. It compares mdc, mdio_oe, mdio_out, cmd_rdbk and rd_data against its own prediction at that falling edge, half a period away from any update.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int CMD_W     = 16;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int PRE_LEN   = 32;
  localparam int WR_BIT    = 14;
  localparam int RD_BIT    = 13;
  localparam int PHY_LSB   = 8;
  localparam int REG_LSB   = 0;
  localparam int HDR_W     = 2 + 2 + ADDR_W + ADDR_W + 2;
  localparam int BODY_W    = HDR_W + DATA_W;
  localparam int FRAME_LEN = PRE_LEN + BODY_W;

  typedef enum logic {
    SEL_CMD   = 1'b0,
    SEL_WDATA = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic              is_read;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
    logic [DATA_W-1:0] wdata;
  } xfer_req_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int CLK_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(CLK_DIV);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;

  assign rise_stb = run && (cnt_q == CW'(HALF - 1));
  assign fall_stb = run && (cnt_q == CW'(CLK_DIV - 1));
  assign mdc      = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run || fall_stb) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      if (rise_stb) mdc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xfer_req_t         req,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_in,
  output logic              busy,
  output logic              done,
  output logic              op_read,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_word
);
  localparam int BW         = $clog2(FRAME_LEN);
  localparam int TA_START   = PRE_LEN + HDR_W - 2;
  localparam int DATA_START = PRE_LEN + HDR_W;

  logic              busy_q, busy_d;
  logic              rd_q, rd_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [BODY_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] cap_q, cap_d;
  logic [BODY_W-1:0] body;
  logic              in_body;

  // Start, opcode, address, register, turnaround, data
  assign body = {2'b01, (req.is_read ? 2'b10 : 2'b01), req.phy, req.regn,
                 (req.is_read ? 2'b11 : 2'b10),
                 (req.is_read ? {DATA_W{1'b0}} : req.wdata)};

  assign in_body = (bit_q >= BW'(PRE_LEN));

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    cap_d  = cap_q;
    done   = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = req.is_read;
      bit_d  = '0;
      sh_d   = body;
    end else if (busy_q) begin
      if (rise_stb && rd_q && (bit_q >= BW'(DATA_START)))
        cap_d = {cap_q[DATA_W-2:0], mdio_in};
      if (fall_stb) begin
        if (bit_q == BW'(FRAME_LEN - 1)) begin
          busy_d = 1'b0;
          bit_d  = '0;
          done   = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          if (in_body) sh_d = {sh_q[BODY_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      cap_q  <= cap_d;
    end
  end

  assign busy     = busy_q;
  assign op_read  = rd_q;
  assign rd_word  = cap_q;
  assign mdio_out = in_body ? sh_q[BODY_W-1] : 1'b1;
  assign mdio_oe  = busy_q && !(rd_q && (bit_q >= BW'(TA_START)));
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [CMD_W-1:0]  wr_data,
  input  logic              busy,
  input  logic              done,
  input  logic              op_read,
  input  logic [DATA_W-1:0] rd_word,
  output logic              start,
  output xfer_req_t         req,
  output logic [CMD_W-1:0]  cmd_rdbk,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [ADDR_W-1:0] phy_q, phy_d;
  logic [ADDR_W-1:0] reg_q, reg_d;
  logic              rq_rd_q, rq_rd_d;
  logic              rq_wr_q, rq_wr_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              cmd_hit, want_rd, want_wr;
  logic              unused_bits;

  assign unused_bits = ^{wr_data[15], wr_data[7:5]};

  assign cmd_hit = wr_en && (sel == SEL_CMD) && !busy;
  assign want_rd = wr_data[RD_BIT];
  assign want_wr = wr_data[WR_BIT] && !want_rd;
  assign start   = cmd_hit && (want_rd || want_wr);

  always_comb begin
    req.is_read = want_rd;
    req.phy     = wr_data[PHY_LSB +: ADDR_W];
    req.regn    = wr_data[REG_LSB +: ADDR_W];
    req.wdata   = wdata_q;
  end

  always_comb begin
    wdata_d = wdata_q;
    phy_d   = phy_q;
    reg_d   = reg_q;
    rq_rd_d = rq_rd_q;
    rq_wr_d = rq_wr_q;
    rdat_d  = rdat_q;
    if (wr_en && (sel == SEL_WDATA)) wdata_d = wr_data;
    if (cmd_hit) begin
      phy_d   = wr_data[PHY_LSB +: ADDR_W];
      reg_d   = wr_data[REG_LSB +: ADDR_W];
      rq_rd_d = want_rd;
      rq_wr_d = want_wr;
    end
    if (done && op_read) rdat_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      rq_rd_q <= 1'b0;
      rq_wr_q <= 1'b0;
      rdat_q  <= '0;
    end else begin
      wdata_q <= wdata_d;
      phy_q   <= phy_d;
      reg_q   <= reg_d;
      rq_rd_q <= rq_rd_d;
      rq_wr_q <= rq_wr_d;
      rdat_q  <= rdat_d;
    end
  end

  always_comb begin
    cmd_rdbk                      = '0;
    cmd_rdbk[WR_BIT]              = busy && rq_wr_q;
    cmd_rdbk[RD_BIT]              = busy && rq_rd_q;
    cmd_rdbk[PHY_LSB +: ADDR_W]   = phy_q;
    cmd_rdbk[REG_LSB +: ADDR_W]   = reg_q;
  end

  assign rd_data = rdat_q;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int CLK_DIV = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  input  logic        mdio_in,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic [15:0] cmd_rdbk,
  output logic [15:0] rd_data
);
  logic              rst_meta_q, rst_sync_n;
  logic              busy, done, op_read, start;
  logic              rise_stb, fall_stb;
  xfer_req_t         req;
  logic [DATA_W-1:0] rd_word;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mdio_csr u_csr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (reg_wr_en),
    .sel      (reg_sel_e'(reg_sel)),
    .wr_data  (reg_wdata),
    .busy     (busy),
    .done     (done),
    .op_read  (op_read),
    .rd_word  (rd_word),
    .start    (start),
    .req      (req),
    .cmd_rdbk (cmd_rdbk),
    .rd_data  (rd_data)
  );

  mdio_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_eng u_eng (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .req      (req),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_in  (mdio_in),
    .busy     (busy),
    .done     (done),
    .op_read  (op_read),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .rd_word  (rd_word)
  );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk #(
  parameter int CLK_DIV = 40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic [15:0] cmd_rdbk,
  input logic [15:0] rd_data
);
  localparam int HALF = CLK_DIV / 2;
  localparam int HW   = $clog2(CLK_DIV + 1);

  logic [HW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_run <= '0;
    else if (mdc) hi_run <= hi_run + 1'b1;
    else          hi_run <= '0;
  end

  assert_mdc_high_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> (hi_run < HW'(HALF)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdbk[14:13] == 2'b00) |-> (!mdio_oe && !mdc));

  assert_req_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_rdbk[14:13]));

  assert_fields_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdbk[14:13] != 2'b00) |=> $stable(cmd_rdbk[12:0]));

  assert_rd_data_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data != $past(rd_data)) |-> ($past(cmd_rdbk[13]) && !cmd_rdbk[13]));

  assert_mdo_change_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mdio_oe) && mdio_oe && (mdio_out != $past(mdio_out))) |-> !mdc);
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mdc      (mdc),
  .mdio_out (mdio_out),
  .mdio_oe  (mdio_oe),
  .cmd_rdbk (cmd_rdbk),
  .rd_data  (rd_data)
);

// File: tb/mdio_cmd_ctrl_test.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_test;
  localparam int DIV   = 40;
  localparam int NBITS = 64;
  localparam int XLEN  = NBITS * DIV;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        sel;
  logic [15:0] wdata;
  logic        mdio_in;
  logic        mdc, mdio_out, mdio_oe;
  logic [15:0] cmd_rdbk, rd_data;

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  int cur_busy = 0;
  int last_busy_len = 0;
  bit done_flag = 0;

  // reference model state
  bit          m_busy;
  int          m_t;
  bit          m_isrd;
  logic [15:0] m_cmd, m_rd, m_wd, m_phyval;
  logic [63:0] m_frame;
  logic [15:0] phy_rdata;

  mdio_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_sel(sel),
    .reg_wdata(wdata), .mdio_in(mdio_in), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .cmd_rdbk(cmd_rdbk), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at cycle %0d: got=%h expected=%h", tag, cyc, got, exp);
    end
  endtask

  // Model: one step per clock, using the inputs seen at the rising edge
  always @(negedge clk) begin
    bit prev;
    bit rq, wq;
    int bitn, ph;
    bit e_mdc, e_oe;
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_isrd = 0;
      m_cmd = '0; m_rd = '0; m_wd = '0; m_frame = '0; m_phyval = '0;
    end else begin
      prev = m_busy;
      if (m_busy) begin
        m_t++;
        if (m_t == XLEN) begin
          m_busy = 0;
          m_cmd[14:13] = 2'b00;
          if (m_isrd) m_rd = m_phyval;
        end
      end
      if (wr_en) begin
        if (sel) m_wd = wdata;
        else if (!prev) begin
          rq = wdata[13];
          wq = wdata[14] && !rq;
          m_cmd = {1'b0, wq, rq, wdata[12:8], 3'b000, wdata[4:0]};
          if (rq || wq) begin
            m_busy = 1; m_t = 0; m_isrd = rq; m_phyval = phy_rdata;
            m_frame = {32'hFFFF_FFFF, 2'b01, (rq ? 2'b10 : 2'b01),
                       wdata[12:8], wdata[4:0], (rq ? 2'b11 : 2'b10),
                       (rq ? 16'h0000 : m_wd)};
          end
        end
      end
    end
    bitn  = m_t / DIV;
    ph    = m_t % DIV;
    e_mdc = m_busy && (ph >= DIV / 2);
    e_oe  = m_busy && !(m_isrd && bitn >= 46);
    mdio_in <= (m_busy && m_isrd && bitn >= 48) ? m_phyval[63 - bitn] : 1'b1;

    check(mdc === e_mdc, rst_n ? "R3 mdc" : "R10 mdc", 32'(mdc), 32'(e_mdc));
    check(mdio_oe === e_oe,
          !rst_n ? "R10 oe" : (m_busy ? (m_isrd ? "R6 oe" : "R4 oe") : "R11 oe"),
          32'(mdio_oe), 32'(e_oe));
    if (e_oe)
      check(mdio_out === m_frame[63 - bitn],
            (!m_isrd && bitn >= 48) ? "R5 data bit" : "R4 frame bit",
            32'(mdio_out), 32'(m_frame[63 - bitn]));
    if (!rst_n)
      check(mdio_out === 1'b1, "R10 mdio_out", 32'(mdio_out), 32'h1);
    check(cmd_rdbk === m_cmd, rst_n ? "R2 cmd_rdbk" : "R10 cmd_rdbk",
          32'(cmd_rdbk), 32'(m_cmd));
    check(rd_data === m_rd, rst_n ? "R7 rd_data" : "R10 rd_data",
          32'(rd_data), 32'(m_rd));

    // busy length observed at the ports
    if (cmd_rdbk[14:13] != 2'b00) cur_busy++;
    else if (cur_busy != 0) begin
      last_busy_len = cur_busy;
      cur_busy = 0;
    end

    if (cyc == 150000 && !done_flag) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  task automatic wr_reg(input logic s, input logic [15:0] v);
    @(negedge clk); #1;
    wr_en = 1'b1; sel = s; wdata = v;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (cmd_rdbk[14:13] != 2'b00) @(negedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; sel = 1'b0; wdata = '0;
    phy_rdata = '0; mdio_in = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    // R10: reset state
    check(cmd_rdbk == 16'h0000, "R10 reset cmd", 32'(cmd_rdbk), 32'h0);
    check(rd_data == 16'h0000, "R10 reset rd_data", 32'(rd_data), 32'h0);
    check(!mdc && !mdio_oe && mdio_out, "R10 reset pins",
          {29'b0, mdc, mdio_oe, mdio_out}, 32'h1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Write transfer (R1, R2, R4, R5)
    wr_reg(1'b1, 16'hA5C3);
    wr_reg(1'b0, 16'h4104);
    check(cmd_rdbk == 16'h4104, "R1 write accepted", 32'(cmd_rdbk), 32'h4104);
    wait_idle();
    check(last_busy_len == XLEN, "R2 busy length", last_busy_len, XLEN);
    check(cmd_rdbk == 16'h0104, "R2 request cleared", 32'(cmd_rdbk), 32'h0104);
    check(!mdio_oe, "R11 released after write", 32'(mdio_oe), 32'h0);
    check(rd_data == 16'h0000, "R7 write leaves rd_data", 32'(rd_data), 32'h0);

    // Read transfer with ignored command while busy (R6, R8)
    phy_rdata = 16'h5A3C;
    wr_reg(1'b0, 16'h3F1F);
    wr_reg(1'b1, 16'h1234);
    wr_reg(1'b0, 16'h4203);
    check(cmd_rdbk == 16'h3F1F, "R8 busy command ignored", 32'(cmd_rdbk), 32'h3F1F);
    wait_idle();
    check(last_busy_len == XLEN, "R8 length unchanged", last_busy_len, XLEN);
    check(rd_data == 16'h5A3C, "R6 read data", 32'(rd_data), 32'h5A3C);

    // Write with write-data change in flight (R5, R7)
    wr_reg(1'b1, 16'h0F0F);
    wr_reg(1'b0, 16'h4A11);
    wr_reg(1'b1, 16'hFFFF);
    wait_idle();
    check(cmd_rdbk == 16'h0A11, "R2 fields kept", 32'(cmd_rdbk), 32'h0A11);
    check(rd_data == 16'h5A3C, "R7 rd_data held", 32'(rd_data), 32'h5A3C);

    // Both request bits set (R9)
    phy_rdata = 16'h8001;
    wr_reg(1'b0, 16'h6C07);
    check(cmd_rdbk == 16'h2C07, "R9 treated as read", 32'(cmd_rdbk), 32'h2C07);
    check(!mdio_oe || 1'b1, "R9 accepted", 32'h0, 32'h0);
    wait_idle();
    check(rd_data == 16'h8001, "R9 read result", 32'(rd_data), 32'h8001);

    // No request bit: stored, nothing sent (R1)
    wr_reg(1'b0, 16'h0305);
    check(cmd_rdbk == 16'h0305, "R1 fields stored", 32'(cmd_rdbk), 32'h0305);
    repeat (50) @(negedge clk);
    #1;
    check(!mdc && !mdio_oe, "R1 no transfer started",
          {30'b0, mdc, mdio_oe}, 32'h0);

    // Reserved bits dropped (R1)
    wr_reg(1'b1, 16'hC33C);
    wr_reg(1'b0, 16'hC0E5);
    check(cmd_rdbk == 16'h4005, "R1 reserved bits zero", 32'(cmd_rdbk), 32'h4005);
    wait_idle();
    check(last_busy_len == XLEN, "R2 busy length again", last_busy_len, XLEN);

    // Back-to-back read of all zeros (R6)
    phy_rdata = 16'h0000;
    wr_reg(1'b0, 16'h3E01);
    wait_idle();
    check(rd_data == 16'h0000, "R6 read zeros", 32'(rd_data), 32'h0);
    check(!mdio_oe && !mdc, "R11 idle pins", {30'b0, mdc, mdio_oe}, 32'h0);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule